// File: doc/BRIEF.md
# Programmable Video Raster Timing Generator

The block walks a video raster with a pixel counter and a line counter and turns the position into the timing flags that a display path needs. These are horizontal and vertical blanking, horizontal and vertical sync, and an interlace field flag. It also substitutes a per-plane black level for the incoming pixel whenever the position lies in blanking. Every boundary, the raster size, the black levels and the output style come from a register bank. The bank takes its reset values at reset, and software changes it through a single-cycle write port.

Writes go to a shadow bank. The working bank copies the shadow bank only when the counters wrap from the last position of a frame back to (0,0), so a frame in progress never mixes two configurations. A restart pulse from an external frame-lock controller moves the counters to a programmable coordinate on the next clock.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset the position is (pixel 0, line 0). The pixel counter counts up to the line-length register and then returns to 0. Each return to pixel 0 advances the line counter. After the line at the frame-height register the line counter returns to 0. Reset values by address 0..25: 23, 13, 0, 0, 6, 2, 4, 10, 2, 5, 7, 12, 5, 11, 3, 12, 3, 4, 14, 5, 14, 0, 64, 512, 512, 0.
- R2: Horizontal blanking holds on every pixel below the value at address 4.
- R3: Vertical blanking holds on the lines of the half-open range [addr 7, addr 8). A range whose start exceeds its end wraps through line 0, and equal ends give an empty range. In interlaced mode the lines of [addr 9, addr 10) are also blanked.
- R4: In interlaced mode the field flag is 1 on the lines of the wrapping half-open range [addr 12, addr 11) and 0 on all other lines. In progressive mode it is always 0.
- R5: Horizontal sync holds on the pixels of the wrapping half-open range [addr 5, addr 6).
- R6: Vertical sync holds on the positions from (line addr 13, pixel addr 14) up to but excluding (line addr 15, pixel addr 16). Positions are ordered by line first, then by pixel, and the range wraps. In interlaced mode the range (addr 17, addr 18) to (addr 19, addr 20) is added.
- R7: Control register address 21 selects the style with bit 0 and interlaced mode with bit 1. In blank style (bit 0 = 1) only hblank and vblank follow R2/R3, and hsync and vsync stay 0. In sync style only hsync and vsync follow R5/R6, and hblank and vblank stay 0. `blank_style` reports bit 0 of the working bank.
- R8: Plane p of `pix_out` carries the low bits of black register 22+p while horizontal or vertical blanking is active, whatever the style. At all other times it carries plane p of `pix_in`.
- R9: A write changes the working value only at the clock edge where the counters wrap from the end of the frame to (0,0). A restart edge is not a wrap. Writes to addresses 26..31 have no effect.
- R10: A restart pulse places the counters at (pixel addr 2, line addr 3) on the next clock. It takes priority over counting and over the frame wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Frame restart pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 16 | Register write data |
| pix_in | input | NPLANES*SBITS | Input pixel, plane 0 in the low bits |
| hblank | output | 1 | Horizontal blanking (blank style) |
| vblank | output | 1 | Vertical blanking (blank style) |
| hsync | output | 1 | Horizontal sync (sync style) |
| vsync | output | 1 | Vertical sync (sync style) |
| field | output | 1 | Interlace field flag |
| blank_style | output | 1 | 1 = blank style, 0 = sync style |
| pix_out | output | NPLANES*SBITS | Pixel or black value |

## Verification
The assertions assume that programmed coordinates fit the counter widths. They also assume the restart input is a clean synchronous level sampled on the clock. The counter-advance and wrap properties further assume the counters are never far past a freshly shrunk total, because the counter then returns to 0 at the next edge. The random stimulus draws totals and boundaries from small ranges well inside the counter widths. It writes random addresses, including unused ones, at random moments, and pulses restart rarely, so wrap, restart and mid-frame writes all occur and overlap.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    localparam int REG_W    = 16;
    localparam int NUM_REGS = 26;
    localparam int ADDR_W   = 5;

    typedef enum logic [ADDR_W-1:0] {
        RA_HTOTAL    = 5'd0,
        RA_VTOTAL    = 5'd1,
        RA_HRST      = 5'd2,
        RA_VRST      = 5'd3,
        RA_HB_END    = 5'd4,
        RA_HS_ON     = 5'd5,
        RA_HS_OFF    = 5'd6,
        RA_VB1_ON    = 5'd7,
        RA_VB1_OFF   = 5'd8,
        RA_VB2_ON    = 5'd9,
        RA_VB2_OFF   = 5'd10,
        RA_FLD_CLR   = 5'd11,
        RA_FLD_SET   = 5'd12,
        RA_VS1_ON_V  = 5'd13,
        RA_VS1_ON_H  = 5'd14,
        RA_VS1_OFF_V = 5'd15,
        RA_VS1_OFF_H = 5'd16,
        RA_VS2_ON_V  = 5'd17,
        RA_VS2_ON_H  = 5'd18,
        RA_VS2_OFF_V = 5'd19,
        RA_VS2_OFF_H = 5'd20,
        RA_CTRL      = 5'd21,
        RA_BLACK0    = 5'd22,
        RA_BLACK1    = 5'd23,
        RA_BLACK2    = 5'd24,
        RA_BLACK3    = 5'd25
    } reg_addr_e;

    typedef logic [NUM_REGS-1:0][REG_W-1:0] cfg_bank_t;

    typedef struct packed {
        logic hblank;
        logic vblank;
        logic hsync;
        logic vsync;
        logic field;
    } tim_flags_t;

    // Half-open range test that wraps when the start lies past the end.
    function automatic logic in_span(input logic [31:0] pos,
                                     input logic [31:0] on,
                                     input logic [31:0] off);
        if (on <= off)
            return (pos >= on) && (pos < off);
        return (pos >= on) || (pos < off);
    endfunction

    function automatic logic [REG_W-1:0] reg_default(input int idx);
        case (idx)
            int'(RA_HTOTAL):    return 16'd23;
            int'(RA_VTOTAL):    return 16'd13;
            int'(RA_HB_END):    return 16'd6;
            int'(RA_HS_ON):     return 16'd2;
            int'(RA_HS_OFF):    return 16'd4;
            int'(RA_VB1_ON):    return 16'd10;
            int'(RA_VB1_OFF):   return 16'd2;
            int'(RA_VB2_ON):    return 16'd5;
            int'(RA_VB2_OFF):   return 16'd7;
            int'(RA_FLD_CLR):   return 16'd12;
            int'(RA_FLD_SET):   return 16'd5;
            int'(RA_VS1_ON_V):  return 16'd11;
            int'(RA_VS1_ON_H):  return 16'd3;
            int'(RA_VS1_OFF_V): return 16'd12;
            int'(RA_VS1_OFF_H): return 16'd3;
            int'(RA_VS2_ON_V):  return 16'd4;
            int'(RA_VS2_ON_H):  return 16'd14;
            int'(RA_VS2_OFF_V): return 16'd5;
            int'(RA_VS2_OFF_H): return 16'd14;
            int'(RA_BLACK0):    return 16'd64;
            int'(RA_BLACK1):    return 16'd512;
            int'(RA_BLACK2):    return 16'd512;
            default:            return 16'd0;
        endcase
    endfunction

endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
    import rtg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [REG_W-1:0]    wr_data,
    input  logic                frame_wrap,
    output cfg_bank_t           cfg
);

    cfg_bank_t shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                shadow[i] <= reg_default(i);
                cfg[i]    <= reg_default(i);
            end
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wr_en && (wr_addr == ADDR_W'(i)))
                    shadow[i] <= wr_data;
                if (frame_wrap)
                    cfg[i] <= shadow[i];
            end
        end
    end

endmodule

// File: rtl/rtg_counters.sv
module rtg_counters #(
    parameter int HB = 12,
    parameter int VB = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic [HB-1:0] htotal,
    input  logic [VB-1:0] vtotal,
    input  logic [HB-1:0] hrst,
    input  logic [VB-1:0] vrst,
    output logic [HB-1:0] h,
    output logic [VB-1:0] v,
    output logic          frame_wrap
);

    logic line_end;
    logic frame_end;

    assign line_end   = (h >= htotal);
    assign frame_end  = line_end && (v >= vtotal);
    assign frame_wrap = frame_end && !restart;

    always_ff @(posedge clk) begin
        if (rst) begin
            h <= '0;
            v <= '0;
        end else if (restart) begin
            h <= hrst;
            v <= vrst;
        end else if (line_end) begin
            h <= '0;
            v <= frame_end ? '0 : v + 1'b1;
        end else begin
            h <= h + 1'b1;
        end
    end

endmodule

// File: rtl/rtg_decode.sv
module rtg_decode
    import rtg_pkg::*;
#(
    parameter int HB      = 12,
    parameter int VB      = 11,
    parameter int NPLANES = 3,
    parameter int SBITS   = 10
) (
    input  logic [HB-1:0]            h,
    input  logic [VB-1:0]            v,
    input  cfg_bank_t                cfg,
    input  logic [NPLANES*SBITS-1:0] pix_in,
    output tim_flags_t               raw,
    output logic [NPLANES*SBITS-1:0] pix_out
);

    logic          interlaced;
    logic [31:0]   pos_h, pos_v, pos_hv;
    logic          in_blank;

    function automatic logic [31:0] hc(input reg_addr_e a);
        return 32'(cfg[a][HB-1:0]);
    endfunction

    function automatic logic [31:0] vc(input reg_addr_e a);
        return 32'(cfg[a][VB-1:0]);
    endfunction

    function automatic logic [31:0] pair(input reg_addr_e av, input reg_addr_e ah);
        return 32'({cfg[av][VB-1:0], cfg[ah][HB-1:0]});
    endfunction

    assign interlaced = cfg[RA_CTRL][1];
    assign pos_h      = 32'(h);
    assign pos_v      = 32'(v);
    assign pos_hv     = 32'({v, h});

    always_comb begin
        raw.hblank = pos_h < hc(RA_HB_END);
        raw.vblank = in_span(pos_v, vc(RA_VB1_ON), vc(RA_VB1_OFF))
                   | (interlaced & in_span(pos_v, vc(RA_VB2_ON), vc(RA_VB2_OFF)));
        raw.hsync  = in_span(pos_h, hc(RA_HS_ON), hc(RA_HS_OFF));
        raw.vsync  = in_span(pos_hv, pair(RA_VS1_ON_V, RA_VS1_ON_H),
                             pair(RA_VS1_OFF_V, RA_VS1_OFF_H))
                   | (interlaced & in_span(pos_hv, pair(RA_VS2_ON_V, RA_VS2_ON_H),
                                           pair(RA_VS2_OFF_V, RA_VS2_OFF_H)));
        raw.field  = interlaced & in_span(pos_v, vc(RA_FLD_SET), vc(RA_FLD_CLR));
    end

    assign in_blank = raw.hblank | raw.vblank;

    for (genvar p = 0; p < NPLANES; p++) begin : g_plane
        assign pix_out[p*SBITS +: SBITS] = in_blank
            ? cfg[int'(RA_BLACK0) + p][SBITS-1:0]
            : pix_in[p*SBITS +: SBITS];
    end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int HBITS   = 12,
    parameter int VBITS   = 11,
    parameter int NPLANES = 3,
    parameter int SBITS   = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     restart,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [REG_W-1:0]         wr_data,
    input  logic [NPLANES*SBITS-1:0] pix_in,
    output logic                     hblank,
    output logic                     vblank,
    output logic                     hsync,
    output logic                     vsync,
    output logic                     field,
    output logic                     blank_style,
    output logic [NPLANES*SBITS-1:0] pix_out
);

    cfg_bank_t        cfg;
    logic             frame_wrap;
    logic [HBITS-1:0] h_cnt, htotal, hrst;
    logic [VBITS-1:0] v_cnt, vtotal, vrst;
    tim_flags_t       raw;
    logic             unused_cfg;

    assign unused_cfg = ^cfg;

    assign htotal = cfg[RA_HTOTAL][HBITS-1:0];
    assign vtotal = cfg[RA_VTOTAL][VBITS-1:0];
    assign hrst   = cfg[RA_HRST][HBITS-1:0];
    assign vrst   = cfg[RA_VRST][VBITS-1:0];

    rtg_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .frame_wrap (frame_wrap),
        .cfg        (cfg)
    );

    rtg_counters #(.HB(HBITS), .VB(VBITS)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .htotal     (htotal),
        .vtotal     (vtotal),
        .hrst       (hrst),
        .vrst       (vrst),
        .h          (h_cnt),
        .v          (v_cnt),
        .frame_wrap (frame_wrap)
    );

    rtg_decode #(.HB(HBITS), .VB(VBITS), .NPLANES(NPLANES), .SBITS(SBITS)) u_dec (
        .h       (h_cnt),
        .v       (v_cnt),
        .cfg     (cfg),
        .pix_in  (pix_in),
        .raw     (raw),
        .pix_out (pix_out)
    );

    assign blank_style = cfg[RA_CTRL][0];
    assign hblank      = blank_style  & raw.hblank;
    assign vblank      = blank_style  & raw.vblank;
    assign hsync       = !blank_style & raw.hsync;
    assign vsync       = !blank_style & raw.vsync;
    assign field       = raw.field;

endmodule

// File: rtl/rtg_chk.sv
module rtg_chk
    import rtg_pkg::*;
#(
    parameter int HB = 12,
    parameter int VB = 11
) (
    input logic          clk,
    input logic          rst,
    input logic          restart,
    input logic [HB-1:0] h,
    input logic [VB-1:0] v,
    input logic [HB-1:0] htotal,
    input logic [VB-1:0] vtotal,
    input logic [HB-1:0] hrst,
    input logic [VB-1:0] vrst,
    input logic          frame_wrap,
    input cfg_bank_t     cfg,
    input logic          blank_style,
    input logic          hblank,
    input logic          vblank,
    input logic          hsync,
    input logic          vsync
);

    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R1
    h_step_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && !restart && (h < htotal) |=> (h == $past(h) + 1'b1) && (v == $past(v)));

    // R1
    frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && !restart && (h >= htotal) && (v >= vtotal) |=> (h == '0) && (v == '0));

    // R10
    restart_pos_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && restart |=> (h == $past(hrst)) && (v == $past(vrst)));

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && !frame_wrap |=> $stable(cfg));

    // R7
    sync_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && blank_style |-> !hsync && !vsync);

    // R7
    blank_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && !blank_style |-> !hblank && !vblank);

    // R2
    hblank_origin_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && blank_style && (h == '0) && (cfg[RA_HB_END][HB-1:0] != '0) |-> hblank);

endmodule

bind raster_timing_gen rtg_chk #(.HB(HBITS), .VB(VBITS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .restart     (restart),
    .h           (h_cnt),
    .v           (v_cnt),
    .htotal      (htotal),
    .vtotal      (vtotal),
    .hrst        (hrst),
    .vrst        (vrst),
    .frame_wrap  (frame_wrap),
    .cfg         (cfg),
    .blank_style (blank_style),
    .hblank      (hblank),
    .vblank      (vblank),
    .hsync       (hsync),
    .vsync       (vsync)
);

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;

    localparam int HBITS  = 12;
    localparam int VBITS  = 11;
    localparam int NPL    = 3;
    localparam int SB     = 10;
    localparam int NREG   = 26;
    localparam int CLK_NS = 20;
    localparam int HM     = (1 << HBITS) - 1;
    localparam int VM     = (1 << VBITS) - 1;
    localparam int SM     = (1 << SB) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              restart = 1'b0;
    logic              wr_en = 1'b0;
    logic [4:0]        wr_addr = '0;
    logic [15:0]       wr_data = '0;
    logic [NPL*SB-1:0] pix_in = '0;
    logic              hblank, vblank, hsync, vsync, field, blank_style;
    logic [NPL*SB-1:0] pix_out;

    raster_timing_gen #(.HBITS(HBITS), .VBITS(VBITS), .NPLANES(NPL), .SBITS(SB)) u0 (
        .clk(clk), .rst(rst), .restart(restart), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pix_in(pix_in), .hblank(hblank), .vblank(vblank),
        .hsync(hsync), .vsync(vsync), .field(field), .blank_style(blank_style),
        .pix_out(pix_out)
    );

    always #(CLK_NS/2) clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int sh [NREG];
    int ac [NREG];
    int mh, mv;

    localparam int DEFS [NREG] = '{23, 13, 0, 0, 6, 2, 4, 10, 2, 5, 7, 12, 5,
                                   11, 3, 12, 3, 4, 14, 5, 14, 0, 64, 512, 512, 0};

    function automatic bit span(longint p, longint a, longint b);
        if (a <= b) return (p >= a) && (p < b);
        return (p >= a) || (p < b);
    endfunction

    task automatic chk(string tag, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        bit il, sty, hb, vb, hs, vs, fd;
        longint hv;
        logic [NPL*SB-1:0] exp_pix;
        il  = ac[21][1];
        sty = ac[21][0];
        hv  = (longint'(mv) << HBITS) | mh;
        hb  = mh < (ac[4] & HM);
        vb  = span(mv, ac[7] & VM, ac[8] & VM) || (il && span(mv, ac[9] & VM, ac[10] & VM));
        hs  = span(mh, ac[5] & HM, ac[6] & HM);
        vs  = span(hv, (longint'(ac[13] & VM) << HBITS) | (ac[14] & HM),
                       (longint'(ac[15] & VM) << HBITS) | (ac[16] & HM))
           || (il && span(hv, (longint'(ac[17] & VM) << HBITS) | (ac[18] & HM),
                              (longint'(ac[19] & VM) << HBITS) | (ac[20] & HM)));
        fd  = il && span(mv, ac[12] & VM, ac[11] & VM);
        for (int p = 0; p < NPL; p++)
            exp_pix[p*SB +: SB] = (hb || vb) ? SB'(ac[22+p] & SM) : pix_in[p*SB +: SB];
        chk({tag, " R2 R7"}, "hblank", hblank, sty && hb);
        chk({tag, " R3 R7"}, "vblank", vblank, sty && vb);
        chk({tag, " R5 R7"}, "hsync", hsync, !sty && hs);
        chk({tag, " R6 R7"}, "vsync", vsync, !sty && vs);
        chk({tag, " R4"}, "field", field, fd);
        chk({tag, " R7"}, "blank_style", blank_style, sty);
        chk({tag, " R8"}, "pix_out", pix_out, exp_pix);
    endtask

    // One clock: drive at the falling edge, check, then follow the rising edge.
    task automatic step(string tag, bit rs, bit we, int a, int d);
        bit wrap;
        restart = rs;
        wr_en   = we;
        wr_addr = a[4:0];
        wr_data = d[15:0];
        pix_in  = (NPL*SB)'($urandom());
        #1;
        check_all(tag);
        @(posedge clk);
        wrap = !rs && (mh >= (ac[0] & HM)) && (mv >= (ac[1] & VM));
        if (rs) begin
            mh = ac[2] & HM;
            mv = ac[3] & VM;
        end else if (mh >= (ac[0] & HM)) begin
            mh = 0;
            mv = wrap ? 0 : mv + 1;
        end else begin
            mh = mh + 1;
        end
        if (wrap) ac = sh;
        if (we && a < NREG) sh[a] = d & 16'hFFFF;
        @(negedge clk);
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_NS * 190000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NREG; i++) begin
            sh[i] = DEFS[i];
            ac[i] = DEFS[i];
        end
        mh = 0;
        mv = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state and two default frames
        step("R1 reset", 0, 0, 0, 0);
        idle("R1", 2 * 24 * 14);

        // R9: mid-frame writes, including an unused address
        idle("R9", 100);
        step("R9", 0, 1, 21, 1);
        step("R9", 0, 1, 30, 16'hFFFF);
        chk("R9", "blank_style before boundary", blank_style, 0);
        step("R9", 0, 1, 22, 16'h3AB);
        idle("R9", 2 * 24 * 14);

        // R10: restart to a programmed coordinate
        step("R10", 0, 1, 2, 7);
        step("R10", 0, 1, 3, 9);
        idle("R10", 24 * 14 + 5);
        step("R10", 1, 0, 0, 0);
        idle("R10 after", 40);
        step("R10", 1, 0, 0, 0);
        step("R10 back to back", 1, 0, 0, 0);
        idle("R10", 30);

        // R4: interlaced, blank style
        step("R4", 0, 1, 21, 3);
        idle("R4", 3 * 24 * 14);

        // Random configuration, writes and restarts
        for (int n = 0; n < 16000; n++) begin
            int a, d;
            bit we, rs;
            we = ($urandom() % 40) == 0;
            rs = ($urandom() % 300) == 0;
            a  = $urandom() % 32;
            case (a)
                0:  d = 10 + $urandom() % 30;
                1:  d = 8 + $urandom() % 24;
                21: d = $urandom() % 4;
                22, 23, 24, 25: d = $urandom() % 65536;
                default: d = $urandom() % 40;
            endcase
            step("rnd", rs, we, a, d);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule